// File: doc/BRIEF.md
# Three-Wire SPI Identification Reader

This block is a serial master for an accelerometer that talks over three-wire SPI. In that mode a single bidirectional data pin carries the command bits from the master and the response bits from the sensor. After reset the block runs a fixed two-frame sequence without being asked. The first frame is a register write that switches the sensor into three-wire mode. The second frame reads the identification register. At the end of the second frame the block presents the identification byte on a parallel output, pulses a valid strobe, and sets a flag if the byte differs from the expected value.

All logic runs on the system clock. The serial clock is a divided copy of it. Every shift and every sample is timed by half-period strobes, and the serial clock itself is never used as a clock. The data pin is split into three signals: an output value, an output enable and an input value. A pad or board-level tristate buffer combines them. The start input reruns the whole sequence when the block is idle, and it is ignored while a sequence is running.

Top module: `tw_spi_id_reader`

## Requirements
- R1: The serial clock idles high. Each high phase and each low phase inside a frame lasts exactly CLK_DIV/2 system clocks.
- R2: The serial clock changes only while cs_n is low. Each frame has exactly 16 falling edges of the serial clock.
- R3: The first frame after reset is the 16-bit word 0x3140, sent most significant bit first. Bit 15 is 0 for a write, bit 14 is 0 (single byte), bits 13..8 are address 0x31 and bits 7..0 are data 0x40. The master changes sdio_out only at falling edges of the serial clock.
- R4: The second frame is a read. Its upper byte is 0x80, which is the read bit in bit 15 together with address 0x00.
- R5: During the eight data bits of the read frame, sdio_oe is low and the pin is sampled on rising serial-clock edges. In every other slot, and whenever cs_n is high, sdio_oe is high.
- R6: When the read frame completes, id_byte takes the eight sampled bits, first-sampled bit as bit 7. id_valid goes high for exactly one system clock. id_byte keeps its value until the next completion.
- R7: id_mismatch is set together with id_valid whenever id_byte differs from 0xE5, and cleared when id_byte equals 0xE5.
- R8: cs_n falls at least half a serial period before the first serial-clock edge of a frame. It rises at least half a period after the last edge. Between frames it stays high for at least one full period.
- R9: A one-clock pulse on start while the block is idle runs the full two-frame sequence again. A start pulse during a sequence has no effect: no extra frame and no extra id_valid pulse.
- R10: While rst is high, cs_n and sclk are high, sdio_oe is high, and id_valid and id_mismatch are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to rerun the sequence (ignored while busy) |
| cs_n | output | 1 | Sensor chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| sdio_out | output | 1 | Value driven on the data pin |
| sdio_oe | output | 1 | Data pin output enable, high to drive |
| sdio_in | input | 1 | Value observed on the data pin |
| id_byte | output | 8 | Last identification byte read |
| id_valid | output | 1 | One-clock strobe when id_byte is updated |
| id_mismatch | output | 1 | High when id_byte is not 0xE5 |

## Verification
The assertions assume that start is a single-clock pulse. They also assume that nothing other than the sensor drives sdio_in while sdio_oe is low. The timing checks assume that CLK_DIV is even and at least 4. The bench sensor model drives the pin only after it has received a command byte with the read bit set, and it releases the pin at the sixteenth rising edge. It flags any cycle in which it and the master both drive the pin. Start pulses are one clock wide and are issued both in the idle state and in the middle of a frame.

// File: rtl/tw_spi_id_reader.sv
module tw_spi_id_reader #(
  parameter int          CLK_DIV   = 50,
  parameter logic [5:0]  CFG_ADDR  = 6'h31,
  parameter logic [7:0]  CFG_VAL   = 8'h40,
  parameter logic [5:0]  ID_ADDR   = 6'h00,
  parameter logic [7:0]  ID_EXPECT = 8'hE5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       cs_n,
  output logic       sclk,
  output logic       sdio_out,
  output logic       sdio_oe,
  input  logic       sdio_in,
  output logic [7:0] id_byte,
  output logic       id_valid,
  output logic       id_mismatch
);

  localparam int          HALF     = CLK_DIV / 2;
  localparam int          DW       = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [15:0] CFG_WORD = {1'b0, 1'b0, CFG_ADDR, CFG_VAL};
  localparam logic [15:0] RD_WORD  = {1'b1, 1'b0, ID_ADDR, 8'h00};

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOW, S_HIGH, S_HOLD, S_GAP1, S_GAP2} st_t;

  st_t         st;
  logic [DW-1:0] div;
  logic        tick, fall_stb, rise_stb;
  logic [15:0] shreg;
  logic [3:0]  bitn;
  logic        rd_frm, req;
  logic [7:0]  rx;

  always_ff @(posedge clk) begin
    if (rst)                        div <= '0;
    else if (div == DW'(HALF - 1))  div <= '0;
    else                            div <= div + 1'b1;
  end

  assign tick     = (div == DW'(HALF - 1));
  assign fall_stb = tick && (st == S_SETUP || (st == S_HIGH && bitn != 4'd0));
  assign rise_stb = tick && (st == S_LOW);

  assign sdio_out = shreg[15];
  assign sdio_oe  = !(rd_frm && (st == S_LOW || st == S_HIGH) && bitn < 4'd8);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cs_n        <= 1'b1;
      sclk        <= 1'b1;
      shreg       <= '0;
      bitn        <= 4'd15;
      rd_frm      <= 1'b0;
      rx          <= '0;
      req         <= 1'b1;
      id_byte     <= '0;
      id_valid    <= 1'b0;
      id_mismatch <= 1'b0;
    end else begin
      id_valid <= 1'b0;
      if (st == S_IDLE && start) req <= 1'b1;
      if (rise_stb) begin
        sclk <= 1'b1;
        if (rd_frm && bitn < 4'd8) rx <= {rx[6:0], sdio_in};
      end
      if (fall_stb) begin
        sclk <= 1'b0;
        if (st == S_HIGH) begin
          bitn  <= bitn - 4'd1;
          shreg <= {shreg[14:0], 1'b0};
        end
      end
      if (tick) begin
        case (st)
          S_IDLE: if (req || start) begin
            req    <= 1'b0;
            cs_n   <= 1'b0;
            shreg  <= CFG_WORD;
            rd_frm <= 1'b0;
            bitn   <= 4'd15;
            st     <= S_SETUP;
          end
          S_SETUP: st <= S_LOW;
          S_LOW:   st <= S_HIGH;
          S_HIGH:  st <= (bitn == 4'd0) ? S_HOLD : S_LOW;
          S_HOLD: begin
            cs_n <= 1'b1;
            st   <= S_GAP1;
          end
          S_GAP1: st <= S_GAP2;
          S_GAP2: if (!rd_frm) begin
            rd_frm <= 1'b1;
            shreg  <= RD_WORD;
            bitn   <= 4'd15;
            cs_n   <= 1'b0;
            st     <= S_SETUP;
          end else begin
            st          <= S_IDLE;
            id_byte     <= rx;
            id_valid    <= 1'b1;
            id_mismatch <= (rx != ID_EXPECT);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  assert_release_in_read_R5: assert property (@(posedge clk) disable iff (rst)
    !sdio_oe |-> (!cs_n && rd_frm));

  assert_valid_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    id_valid |=> !id_valid);

  assert_id_held_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(id_byte) |-> id_valid);

  assert_mismatch_flag_R7: assert property (@(posedge clk) disable iff (rst)
    id_valid |-> (id_mismatch == (id_byte != ID_EXPECT)));

  assert_cs_release_high_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> ($past(sclk) && sclk));

  assert_out_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sdio_out) && !cs_n && !$rose(cs_n) && !$fell(cs_n)) |-> $fell(sclk));

endmodule

// File: tb/tb_tw_spi_id_reader.sv
module tb_tw_spi_id_reader;
  localparam int CLK_DIV = 8;
  localparam int HALF    = CLK_DIV / 2;

  logic clk = 1'b0;
  logic rst, start;
  logic cs_n, sclk, sdio_out, sdio_oe, sdio_in;
  logic [7:0] id_byte;
  logic id_valid, id_mismatch;

  always #4 clk = ~clk;

  logic s_oe, s_val;
  assign sdio_in = sdio_oe ? sdio_out : (s_oe ? s_val : 1'b1);

  tw_spi_id_reader #(.CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rst(rst), .start(start), .cs_n(cs_n), .sclk(sclk),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdio_in(sdio_in),
    .id_byte(id_byte), .id_valid(id_valid), .id_mismatch(id_mismatch));

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0]  s_resp;
  logic [15:0] s_sh;
  logic [15:0] frames [0:7];
  int  s_rcnt, nframes, cs_falls, nvalid, nfall, cyc_cs, cyc_edge;
  bit  s_rd, first_fall, p_cs, p_sclk;

  initial begin
    s_oe = 1'b0; s_val = 1'b1; s_sh = '0; s_rcnt = 0; nframes = 0;
    cs_falls = 0; nvalid = 0; nfall = 0; cyc_cs = 0; cyc_edge = 0;
    s_rd = 1'b0; first_fall = 1'b0; p_cs = 1'b1; p_sclk = 1'b1;
    for (int i = 0; i < 8; i++) frames[i] = '0;
  end

  always @(negedge clk) begin
    if (rst) begin
      p_cs = 1'b1; p_sclk = 1'b1; s_oe = 1'b0;
    end else begin
      if (id_valid) nvalid++;
      if (p_cs && !cs_n) begin
        if (cs_falls > 0) chk(cyc_cs >= 2*HALF, "R8 cs gap", cyc_cs, 2*HALF);
        cs_falls++; s_rcnt = 0; s_sh = '0; s_rd = 1'b0;
        first_fall = 1'b1; nfall = 0; cyc_cs = 0;
      end
      if (!p_cs && cs_n) begin
        frames[nframes % 8] = s_sh; nframes++;
        chk(cyc_edge >= HALF, "R8 cs hold", cyc_edge, HALF);
        chk(nfall == 16, "R2 falls per frame", nfall, 16);
        s_oe = 1'b0; cyc_cs = 0;
      end
      if (p_sclk != sclk && cs_n && p_cs)
        chk(1'b0, "R2 sclk moved with cs high", sclk, p_sclk);
      if (p_sclk && !sclk && !cs_n) begin
        nfall++;
        if (first_fall) chk(cyc_cs >= HALF, "R8 cs setup", cyc_cs, HALF);
        else            chk(cyc_edge == HALF, "R1 high phase", cyc_edge, HALF);
        first_fall = 1'b0; cyc_edge = 0;
        if (s_rd && s_rcnt >= 8) begin
          s_oe = 1'b1; s_val = s_resp[15 - s_rcnt];
        end
      end
      if (!p_sclk && sclk && !cs_n) begin
        chk(cyc_edge == HALF, "R1 low phase", cyc_edge, HALF);
        cyc_edge = 0;
        s_sh = {s_sh[14:0], sdio_in};
        s_rcnt++;
        if (s_rcnt == 8) s_rd = s_sh[7];
        if (s_rcnt == 16) s_oe = 1'b0;
      end
      if (sdio_oe && s_oe) chk(1'b0, "R5 bus contention", 1, 0);
      if (cs_n && !sdio_oe) chk(1'b0, "R5 released with cs high", 0, 1);
      cyc_cs++; cyc_edge++;
      p_cs = cs_n; p_sclk = sclk;
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_valid(input string req);
    int n = 0;
    while (!id_valid && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(id_valid, req, 0, 1);
  endtask

  localparam logic [8:0] VEC [0:5] = '{
    {8'hE5, 1'b0}, {8'h00, 1'b1}, {8'hFF, 1'b1},
    {8'hE4, 1'b1}, {8'h65, 1'b1}, {8'hE5, 1'b0}};

  initial begin
    int base, falls0, valid0;
    rst = 1'b1; start = 1'b0; s_resp = 8'hE5;
    repeat (5) @(negedge clk);
    chk(cs_n && sclk, "R10 cs/sclk in reset", {cs_n, sclk}, 3);
    chk(sdio_oe == 1'b1, "R10 oe in reset", sdio_oe, 1);
    chk(!id_valid && !id_mismatch, "R10 flags in reset", {id_valid, id_mismatch}, 0);
    rst = 1'b0;

    wait_valid("R6 auto sequence valid");
    chk(id_byte == 8'hE5, "R6 auto id", id_byte, 8'hE5);
    chk(id_mismatch == 1'b0, "R7 auto match", id_mismatch, 0);
    chk(frames[0] == 16'h3140, "R3 config frame", frames[0], 16'h3140);
    chk(frames[1][15:8] == 8'h80, "R4 read cmd", frames[1][15:8], 8'h80);
    chk(frames[1][7:0] == 8'hE5, "R5 response bits", frames[1][7:0], 8'hE5);
    @(negedge clk);
    chk(id_valid == 1'b0, "R6 valid one cycle", id_valid, 0);

    falls0 = cs_falls;
    repeat (400) @(negedge clk);
    chk(cs_falls == falls0, "R9 stays idle", cs_falls, falls0);

    for (int i = 0; i < 6; i++) begin
      s_resp = VEC[i][8:1];
      base   = nframes;
      falls0 = cs_falls;
      pulse_start();
      wait_valid("R9 start reruns");
      chk(id_byte == VEC[i][8:1], "R6 id byte", id_byte, VEC[i][8:1]);
      chk(id_mismatch == VEC[i][0], "R7 mismatch", id_mismatch, VEC[i][0]);
      chk(frames[base % 8] == 16'h3140, "R3 config frame rerun", frames[base % 8], 16'h3140);
      chk(frames[(base + 1) % 8][15:8] == 8'h80, "R4 read cmd rerun",
          frames[(base + 1) % 8][15:8], 8'h80);
      chk(cs_falls - falls0 == 2, "R9 two frames", cs_falls - falls0, 2);
      repeat (3) @(negedge clk);
      chk(id_byte == VEC[i][8:1], "R6 id held", id_byte, VEC[i][8:1]);
    end

    s_resp = 8'h3C;
    falls0 = cs_falls;
    valid0 = nvalid;
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    repeat (100) @(negedge clk);
    pulse_start();
    wait_valid("R9 busy run valid");
    repeat (600) @(negedge clk);
    chk(cs_falls - falls0 == 2, "R9 busy start ignored", cs_falls - falls0, 2);
    chk(nvalid - valid0 == 1, "R9 single valid", nvalid - valid0, 1);
    chk(id_byte == 8'h3C && id_mismatch, "R7 mismatch 3C", {id_mismatch, id_byte}, 9'h13C);

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(cs_n && sclk && sdio_oe && !id_valid && !id_mismatch, "R10 reset again",
        {cs_n, sclk, sdio_oe, id_valid, id_mismatch}, 5'b11100);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule